// File: doc/BRIEF.md
# Integer Execute Unit for a Three-Operand RISC Pipeline

This block sits in the execute stage of a 32-bit load/store processor. Each cycle it may accept one instruction word together with the two operand values that the register file read for the instruction's source fields. It decodes the word and performs the operation. One clock later it presents a registered write-back request: a destination index, a data word and a write strobe. It also reports a signed-overflow flag and a flag for an encoding it does not recognise. Fetch, memory, branches and trap handling live elsewhere. The overflow and illegal flags are the only way the block tells the surrounding pipeline that an instruction must not retire.

The block covers several groups of work. Register-form instructions share opcode zero and are told apart by a 6-bit function code in the low bits. Immediate-form instructions carry their own opcode and a 16-bit constant, which is always zero-extended. The shifts take their count either from a 5-bit field in the instruction or from the low bits of a source register. Multiply and divide results go to a private pair of high/low result registers rather than to the register file. Two move instructions copy those registers into a general register. The surrounding pipeline supplies operand values, but register index zero is forced to read as zero here, and any write aimed at it is dropped.

Top module: `int_exec_unit`

## Requirements
- R1: While `rst` is high at a clock edge, and afterwards until the first instruction completes, `out_valid`, `wr_en`, `ovf` and `illegal` are 0. Both the high and the low result registers are cleared to zero by reset.
- R2: An instruction accepted with `in_valid`=1 at edge N produces `out_valid`=1 after edge N+1, and only then. Register-form function codes are: 0x20 add, 0x21 addu, 0x22 sub, 0x23 subu, 0x24 and, 0x25 or, 0x26 xor, 0x27 nor. For these, the destination is instr[15:11], operand 1 comes from instr[25:21] and operand 2 from instr[20:16].
- R3: The immediate forms are opcodes 0x08 addi, 0x09 addiu, 0x0C andi, 0x0D ori and 0x0E xori. Their 16-bit constant instr[15:0] is zero-extended, the source is instr[25:21] and the destination is instr[20:16].
- R4: Opcode 0x0F writes the constant into the upper 16 bits of the destination instr[20:16] and zero into the lower 16 bits.
- R5: The shifts act on operand 2. Function codes 0x00 (left), 0x02 (logical right) and 0x03 (arithmetic right) take their count from instr[10:6]. Codes 0x04, 0x06 and 0x07 perform the same three shifts with only the low 5 bits of operand 1 as the count.
- R6: A source field equal to 0 supplies the value 0, whatever value is presented on the operand port.
- R7: A result whose destination index is 0 completes with `out_valid`=1 and `wr_en`=0.
- R8: add, addi and sub set `ovf` on signed overflow and then do not write. addu, addiu and subu wrap and never set `ovf`.
- R9: Function code 0x18 (signed) and 0x19 (unsigned) multiply the two operands. The upper 32 product bits go to the high register and the lower 32 to the low register; no general register is written.
- R10: Function code 0x1A (signed, truncating toward zero) and 0x1B (unsigned) divide operand 1 by operand 2. The quotient goes to the low register and the remainder to the high register. A zero divisor leaves both registers unchanged.
- R11: Function code 0x10 copies the high register and 0x12 copies the low register to instr[15:11]. A copy issued in the cycle right after a multiply or divide sees that operation's result.
- R12: Any other function code under opcode 0, and any opcode not listed above, sets `illegal` and gives `wr_en`=0. Neither result register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands are presented this cycle |
| instr | input | 32 | Instruction word |
| rs_val | input | 32 | Register value read for field instr[25:21] |
| rt_val | input | 32 | Register value read for field instr[20:16] |
| out_valid | output | 1 | A result is presented this cycle |
| wr_en | output | 1 | Write `wr_data` to register `wr_idx` |
| wr_idx | output | 5 | Destination register index |
| wr_data | output | 32 | Result value |
| ovf | output | 1 | Signed overflow; the write was suppressed |
| illegal | output | 1 | Unrecognised encoding; nothing was written |

## Verification
Some properties are checked on every cycle. No write strobe appears without a result, and none targets register zero. A result never carries both a write and a fault flag. A result appears only in the cycle after an accepted instruction. The high/low pair never moves in a cycle that follows no accepted instruction. Other behaviour can only be shown by the bench's scenarios. These include the value of each operation, zero extension of constants, shift count selection, overflow boundaries, signed division rounding, the zero-divisor hold, and the forwarding of a multiply into a move issued the very next cycle.

// File: rtl/iex_pkg.sv
package iex_pkg;

  localparam int unsigned OPC_W  = 6;
  localparam int unsigned FUNC_W = 6;

  // major opcodes
  localparam logic [OPC_W-1:0] OPC_REG   = 6'h00;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 6'h08;
  localparam logic [OPC_W-1:0] OPC_ADDIU = 6'h09;
  localparam logic [OPC_W-1:0] OPC_ANDI  = 6'h0C;
  localparam logic [OPC_W-1:0] OPC_ORI   = 6'h0D;
  localparam logic [OPC_W-1:0] OPC_XORI  = 6'h0E;
  localparam logic [OPC_W-1:0] OPC_LUI   = 6'h0F;

  // register-form function codes
  localparam logic [FUNC_W-1:0] FN_SLL   = 6'h00;
  localparam logic [FUNC_W-1:0] FN_SRL   = 6'h02;
  localparam logic [FUNC_W-1:0] FN_SRA   = 6'h03;
  localparam logic [FUNC_W-1:0] FN_SLLV  = 6'h04;
  localparam logic [FUNC_W-1:0] FN_SRLV  = 6'h06;
  localparam logic [FUNC_W-1:0] FN_SRAV  = 6'h07;
  localparam logic [FUNC_W-1:0] FN_MFHI  = 6'h10;
  localparam logic [FUNC_W-1:0] FN_MFLO  = 6'h12;
  localparam logic [FUNC_W-1:0] FN_MULT  = 6'h18;
  localparam logic [FUNC_W-1:0] FN_MULTU = 6'h19;
  localparam logic [FUNC_W-1:0] FN_DIV   = 6'h1A;
  localparam logic [FUNC_W-1:0] FN_DIVU  = 6'h1B;
  localparam logic [FUNC_W-1:0] FN_ADD   = 6'h20;
  localparam logic [FUNC_W-1:0] FN_ADDU  = 6'h21;
  localparam logic [FUNC_W-1:0] FN_SUB   = 6'h22;
  localparam logic [FUNC_W-1:0] FN_SUBU  = 6'h23;
  localparam logic [FUNC_W-1:0] FN_AND   = 6'h24;
  localparam logic [FUNC_W-1:0] FN_OR    = 6'h25;
  localparam logic [FUNC_W-1:0] FN_XOR   = 6'h26;
  localparam logic [FUNC_W-1:0] FN_NOR   = 6'h27;

  typedef enum logic [4:0] {
    XOP_NONE,
    XOP_ADD, XOP_ADDU, XOP_SUB, XOP_SUBU,
    XOP_AND, XOP_OR, XOP_XOR, XOP_NOR,
    XOP_SLL, XOP_SRL, XOP_SRA,
    XOP_LUI,
    XOP_MFHI, XOP_MFLO,
    XOP_MULT, XOP_MULTU, XOP_DIV, XOP_DIVU
  } xop_e;

  typedef struct packed {
    xop_e       op;
    logic       use_imm;    // operand 2 is the zero-extended constant
    logic       var_shift;  // shift count from operand 1
    logic       gpr_write;  // result targets a general register
    logic       ovf_check;  // signed overflow suppresses the write
    logic       muldiv;     // result goes to the high/low pair
    logic       illegal;
    logic [4:0] dest;
  } decode_t;

endpackage

// File: rtl/iex_decode.sv
module iex_decode
  import iex_pkg::*;
#(
  parameter int unsigned INSTR_W = 32,
  parameter int unsigned IDX_W   = 5
) (
  input  logic [INSTR_W-1:0] instr,
  output decode_t            dec
);

  localparam int unsigned OPC_LSB = INSTR_W - OPC_W;
  localparam int unsigned RT_LSB  = OPC_LSB - 2*IDX_W;
  localparam int unsigned RD_LSB  = RT_LSB - IDX_W;

  logic [OPC_W-1:0]  opc;
  logic [FUNC_W-1:0] fn;
  logic [IDX_W-1:0]  rt_f;
  logic [IDX_W-1:0]  rd_f;

  assign opc  = instr[INSTR_W-1:OPC_LSB];
  assign fn   = instr[FUNC_W-1:0];
  assign rt_f = instr[RT_LSB +: IDX_W];
  assign rd_f = instr[RD_LSB +: IDX_W];

  // register-form group
  function automatic decode_t dec_reg(input logic [FUNC_W-1:0] f,
                                      input logic [IDX_W-1:0] rd);
    decode_t d;
    d           = '0;
    d.op        = XOP_NONE;
    d.dest      = rd;
    d.gpr_write = 1'b1;
    unique case (f)
      FN_ADD:   begin d.op = XOP_ADD; d.ovf_check = 1'b1; end
      FN_ADDU:  d.op = XOP_ADDU;
      FN_SUB:   begin d.op = XOP_SUB; d.ovf_check = 1'b1; end
      FN_SUBU:  d.op = XOP_SUBU;
      FN_AND:   d.op = XOP_AND;
      FN_OR:    d.op = XOP_OR;
      FN_XOR:   d.op = XOP_XOR;
      FN_NOR:   d.op = XOP_NOR;
      FN_SLL:   d.op = XOP_SLL;
      FN_SRL:   d.op = XOP_SRL;
      FN_SRA:   d.op = XOP_SRA;
      FN_SLLV:  begin d.op = XOP_SLL; d.var_shift = 1'b1; end
      FN_SRLV:  begin d.op = XOP_SRL; d.var_shift = 1'b1; end
      FN_SRAV:  begin d.op = XOP_SRA; d.var_shift = 1'b1; end
      FN_MFHI:  d.op = XOP_MFHI;
      FN_MFLO:  d.op = XOP_MFLO;
      FN_MULT, FN_MULTU, FN_DIV, FN_DIVU: begin
        d.gpr_write = 1'b0;
        d.muldiv    = 1'b1;
        d.dest      = '0;
        d.op = (f == FN_MULT)  ? XOP_MULT  :
               (f == FN_MULTU) ? XOP_MULTU :
               (f == FN_DIV)   ? XOP_DIV   : XOP_DIVU;
      end
      default: begin
        d.illegal   = 1'b1;
        d.gpr_write = 1'b0;
      end
    endcase
    return d;
  endfunction

  always_comb begin
    dec         = '0;
    dec.op      = XOP_NONE;
    dec.dest    = rt_f;
    dec.use_imm = 1'b1;
    dec.gpr_write = 1'b1;
    unique case (opc)
      OPC_REG:   dec = dec_reg(fn, rd_f);
      OPC_ADDI:  begin dec.op = XOP_ADD; dec.ovf_check = 1'b1; end
      OPC_ADDIU: dec.op = XOP_ADDU;
      OPC_ANDI:  dec.op = XOP_AND;
      OPC_ORI:   dec.op = XOP_OR;
      OPC_XORI:  dec.op = XOP_XOR;
      OPC_LUI:   dec.op = XOP_LUI;
      default: begin
        dec.illegal   = 1'b1;
        dec.gpr_write = 1'b0;
        dec.use_imm   = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/iex_alu.sv
module iex_alu
  import iex_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W  = 16
) (
  input  xop_e                       op,
  input  logic [DATA_W-1:0]          a,
  input  logic [DATA_W-1:0]          b,
  input  logic [IMM_W-1:0]           imm,
  input  logic                       var_shift,
  input  logic [$clog2(DATA_W)-1:0]  shamt,
  output logic [DATA_W-1:0]          result,
  output logic                       sgn_ovf
);

  localparam int unsigned SH_W = $clog2(DATA_W);
  localparam int unsigned MSB  = DATA_W - 1;

  logic [SH_W-1:0]   cnt;
  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] diff;

  assign cnt  = var_shift ? a[SH_W-1:0] : shamt;
  assign sum  = a + b;
  assign diff = a - b;

  always_comb begin
    result  = '0;
    sgn_ovf = 1'b0;
    unique case (op)
      XOP_ADD: begin
        result  = sum;
        sgn_ovf = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
      end
      XOP_ADDU: result = sum;
      XOP_SUB: begin
        result  = diff;
        sgn_ovf = (a[MSB] != b[MSB]) && (diff[MSB] != a[MSB]);
      end
      XOP_SUBU: result = diff;
      XOP_AND:  result = a & b;
      XOP_OR:   result = a | b;
      XOP_XOR:  result = a ^ b;
      XOP_NOR:  result = ~(a | b);
      XOP_SLL:  result = b << cnt;
      XOP_SRL:  result = b >> cnt;
      XOP_SRA:  result = DATA_W'($signed(b) >>> cnt);
      XOP_LUI:  result = {imm, {(DATA_W-IMM_W){1'b0}}};
      default:  result = '0;
    endcase
  end

endmodule

// File: rtl/iex_muldiv.sv
module iex_muldiv
  import iex_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  xop_e              op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] hi,
  output logic [DATA_W-1:0] lo
);

  localparam int unsigned PW  = 2 * DATA_W;
  localparam int unsigned MSB = DATA_W - 1;

  logic [PW-1:0]     prod;
  logic              sgn;
  logic [DATA_W-1:0] ua, ub, q_mag, r_mag, quo, rem;
  logic              q_neg, r_neg, div_op, zero_div;

  assign sgn = (op == XOP_MULT) || (op == XOP_DIV);

  // product of operands widened by sign or zero
  always_comb begin
    logic [PW-1:0] xa, xb;
    xa   = {{DATA_W{sgn & a[MSB]}}, a};
    xb   = {{DATA_W{sgn & b[MSB]}}, b};
    prod = xa * xb;
  end

  // signed divide done on magnitudes, signs restored afterwards
  assign ua    = (sgn && a[MSB]) ? (~a + 1'b1) : a;
  assign ub    = (sgn && b[MSB]) ? (~b + 1'b1) : b;
  assign zero_div = (b == '0);
  assign q_mag = zero_div ? '0 : (ua / ub);
  assign r_mag = zero_div ? '0 : (ua % ub);
  assign q_neg = sgn && (a[MSB] ^ b[MSB]);
  assign r_neg = sgn && a[MSB];
  assign quo   = q_neg ? (~q_mag + 1'b1) : q_mag;
  assign rem   = r_neg ? (~r_mag + 1'b1) : r_mag;
  assign div_op = (op == XOP_DIV) || (op == XOP_DIVU);

  always_ff @(posedge clk) begin
    if (rst) begin
      hi <= '0;
      lo <= '0;
    end else if (start) begin
      if (div_op) begin
        if (!zero_div) begin
          hi <= rem;
          lo <= quo;
        end
      end else begin
        hi <= prod[PW-1:DATA_W];
        lo <= prod[DATA_W-1:0];
      end
    end
  end

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import iex_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned INSTR_W = 32,
  parameter int unsigned IDX_W   = 5,
  parameter int unsigned IMM_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [INSTR_W-1:0] instr,
  input  logic [DATA_W-1:0]  rs_val,
  input  logic [DATA_W-1:0]  rt_val,
  output logic               out_valid,
  output logic               wr_en,
  output logic [IDX_W-1:0]   wr_idx,
  output logic [DATA_W-1:0]  wr_data,
  output logic               ovf,
  output logic               illegal
);

  localparam int unsigned SH_W   = $clog2(DATA_W);
  localparam int unsigned RS_LSB = INSTR_W - OPC_W - IDX_W;
  localparam int unsigned RT_LSB = RS_LSB - IDX_W;
  localparam int unsigned SA_LSB = FUNC_W;

  decode_t           dec;
  logic [IDX_W-1:0]  rs_idx, rt_idx;
  logic [DATA_W-1:0] op_a, rt_z, op_b;
  logic [IMM_W-1:0]  imm;
  logic [DATA_W-1:0] alu_res, res;
  logic              alu_ovf;
  logic [DATA_W-1:0] hi_q, lo_q;
  logic              md_start;
  logic              do_write;

  assign rs_idx = instr[RS_LSB +: IDX_W];
  assign rt_idx = instr[RT_LSB +: IDX_W];
  assign imm    = instr[IMM_W-1:0];

  // index zero always reads as zero
  assign op_a = (rs_idx == '0) ? '0 : rs_val;
  assign rt_z = (rt_idx == '0) ? '0 : rt_val;
  assign op_b = dec.use_imm ? {{(DATA_W-IMM_W){1'b0}}, imm} : rt_z;

  iex_decode #(.INSTR_W(INSTR_W), .IDX_W(IDX_W)) u_dec (
    .instr (instr),
    .dec   (dec)
  );

  iex_alu #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_alu (
    .op        (dec.op),
    .a         (op_a),
    .b         (op_b),
    .imm       (imm),
    .var_shift (dec.var_shift),
    .shamt     (instr[SA_LSB +: SH_W]),
    .result    (alu_res),
    .sgn_ovf   (alu_ovf)
  );

  assign md_start = in_valid && dec.muldiv && !dec.illegal;

  iex_muldiv #(.DATA_W(DATA_W)) u_md (
    .clk   (clk),
    .rst   (rst),
    .start (md_start),
    .op    (dec.op),
    .a     (op_a),
    .b     (rt_z),
    .hi    (hi_q),
    .lo    (lo_q)
  );

  always_comb begin
    unique case (dec.op)
      XOP_MFHI: res = hi_q;
      XOP_MFLO: res = lo_q;
      default:  res = alu_res;
    endcase
  end

  assign do_write = dec.gpr_write && !dec.illegal &&
                    !(dec.ovf_check && alu_ovf) && (dec.dest != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      wr_en     <= 1'b0;
      wr_idx    <= '0;
      wr_data   <= '0;
      ovf       <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      wr_en     <= in_valid && do_write;
      ovf       <= in_valid && dec.ovf_check && alu_ovf;
      illegal   <= in_valid && dec.illegal;
      if (in_valid) begin
        wr_idx  <= dec.dest;
        wr_data <= res;
      end
    end
  end

endmodule

// File: rtl/iex_checker.sv
module iex_checker #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              out_valid,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic              ovf,
  input logic              illegal,
  input logic [DATA_W-1:0] hi_q,
  input logic [DATA_W-1:0] lo_q
);

  // R2
  strobe_in_result_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> out_valid);

  // R2
  result_follows_issue_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

  // R7
  no_zero_dest_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_idx != '0));

  // R8
  no_overflow_write_chk: assert property (@(posedge clk) disable iff (rst)
    ovf |-> (!wr_en && out_valid));

  // R12
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!wr_en && !ovf && out_valid));

  // R10
  hilo_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(in_valid) |-> ($stable(hi_q) && $stable(lo_q)));

endmodule

bind int_exec_unit iex_checker #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .ovf       (ovf),
  .illegal   (illegal),
  .hi_q      (hi_q),
  .lo_q      (lo_q)
);

// File: tb/tb_int_exec_unit.sv
module tb_int_exec_unit;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] rs_val = '0;
  logic [31:0] rt_val = '0;
  logic        out_valid, wr_en, ovf, illegal;
  logic [4:0]  wr_idx;
  logic [31:0] wr_data;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    logic        wr;
    logic [4:0]  idx;
    logic [31:0] data;
    logic        ovf;
    logic        ill;
    string       tag;
  } exp_t;

  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  int_exec_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .rs_val(rs_val), .rt_val(rt_val), .out_valid(out_valid),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .ovf(ovf), .illegal(illegal)
  );

  function automatic logic [31:0] rf(input logic [5:0] f, input logic [4:0] s,
                                     input logic [4:0] t, input logic [4:0] d,
                                     input logic [4:0] sh);
    return {6'h00, s, t, d, sh, f};
  endfunction

  function automatic logic [31:0] imf(input logic [5:0] o, input logic [4:0] s,
                                      input logic [4:0] t, input logic [15:0] k);
    return {o, s, t, k};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: presents one instruction and queues its expected outcome
  task automatic issue(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                       input logic w, input logic [4:0] idx, input logic [31:0] data,
                       input logic ov, input logic il, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1;
    instr    = ins;
    rs_val   = a;
    rt_val   = b;
    e.wr = w; e.idx = idx; e.data = data; e.ovf = ov; e.ill = il; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    instr    = 32'hFFFF_FFFF;
  endtask

  // monitor: compares each result with the oldest queued expectation
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (sb.size() == 0) begin
        chk("R2 unexpected result", 64'(out_valid), 64'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk({e.tag, " flags"}, {61'd0, wr_en, ovf, illegal}, {61'd0, e.wr, e.ovf, e.ill});
        if (e.wr) chk({e.tag, " data"}, {27'd0, wr_idx, wr_data}, {27'd0, e.idx, e.data});
      end
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 reset outputs", {60'd0, out_valid, wr_en, ovf, illegal}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle after reset", {63'd0, out_valid}, 64'd0);

    // R1: result registers cleared by reset
    issue(rf(6'h10, 0, 0, 3, 0), 0, 0, 1, 3, 32'h0, 0, 0, "R1 mfhi after reset");
    issue(rf(6'h12, 0, 0, 4, 0), 0, 0, 1, 4, 32'h0, 0, 0, "R1 mflo after reset");

    // R2: register-form arithmetic and logic
    issue(rf(6'h20, 1, 2, 5, 0), 5, 7, 1, 5, 32'd12, 0, 0, "R2 add");
    issue(rf(6'h22, 1, 2, 5, 0), 10, 3, 1, 5, 32'd7, 0, 0, "R2 sub");
    issue(rf(6'h23, 1, 2, 6, 0), 3, 10, 1, 6, 32'hFFFF_FFF9, 0, 0, "R2 subu");
    issue(rf(6'h24, 1, 2, 9, 0), 32'hF0F0_1234, 32'h0FF0_FF00, 1, 9, 32'h00F0_1200, 0, 0, "R2 and");
    issue(rf(6'h25, 1, 2, 9, 0), 32'hF0F0_1234, 32'h0FF0_FF00, 1, 9, 32'hFFF0_FF34, 0, 0, "R2 or");
    issue(rf(6'h26, 1, 2, 9, 0), 32'hF0F0_1234, 32'h0FF0_FF00, 1, 9, 32'hFF00_ED34, 0, 0, "R2 xor");
    issue(rf(6'h27, 1, 2, 9, 0), 32'hF0F0_1234, 32'h0FF0_FF00, 1, 9, 32'h000F_00CB, 0, 0, "R2 nor");
    idle();

    // R3: zero-extended immediates, destination in the rt field
    issue(imf(6'h08, 1, 6, 16'hFFFF), 32'd1, 32'hDEAD, 1, 6, 32'h0001_0000, 0, 0, "R3 addi");
    issue(imf(6'h0C, 1, 6, 16'hF0F0), 32'h1234_5678, 0, 1, 6, 32'h0000_5070, 0, 0, "R3 andi");
    issue(imf(6'h0D, 1, 7, 16'h00FF), 32'h1234_0000, 0, 1, 7, 32'h1234_00FF, 0, 0, "R3 ori");
    issue(imf(6'h0E, 1, 7, 16'h0F0F), 32'hFFFF_FFFF, 0, 1, 7, 32'hFFFF_F0F0, 0, 0, "R3 xori");

    // R4
    issue(imf(6'h0F, 0, 7, 16'hABCD), 32'h1111_1111, 32'h2222_2222, 1, 7, 32'hABCD_0000, 0, 0, "R4 lui");

    // R5: fixed and variable shifts
    issue(rf(6'h00, 0, 2, 8, 4), 0, 32'h1, 1, 8, 32'h10, 0, 0, "R5 sll");
    issue(rf(6'h02, 0, 2, 8, 31), 0, 32'h8000_0000, 1, 8, 32'h1, 0, 0, "R5 srl");
    issue(rf(6'h03, 0, 2, 8, 4), 0, 32'h8000_0000, 1, 8, 32'hF800_0000, 0, 0, "R5 sra");
    issue(rf(6'h04, 1, 2, 8, 9), 32'h23, 32'h1, 1, 8, 32'h8, 0, 0, "R5 sllv");
    issue(rf(6'h06, 1, 2, 8, 0), 32'hFFFF_FFE4, 32'hF0, 1, 8, 32'hF, 0, 0, "R5 srlv");
    issue(rf(6'h07, 1, 2, 8, 0), 32'h1, 32'h8000_0000, 1, 8, 32'hC000_0000, 0, 0, "R5 srav");

    // R6: index zero reads zero
    issue(rf(6'h20, 0, 2, 8, 0), 32'h55, 32'd3, 1, 8, 32'd3, 0, 0, "R6 rs zero");
    issue(rf(6'h21, 1, 0, 8, 0), 32'd9, 32'h77, 1, 8, 32'd9, 0, 0, "R6 rt zero");
    issue(imf(6'h08, 0, 8, 16'd5), 32'd99, 0, 1, 8, 32'd5, 0, 0, "R6 addi rs zero");

    // R7: write to register zero dropped
    issue(rf(6'h21, 1, 2, 0, 0), 32'd1, 32'd1, 0, 0, 0, 0, 0, "R7 dest zero");

    // R8: overflow cases
    issue(rf(6'h20, 1, 2, 10, 0), 32'h7FFF_FFFF, 32'h1, 0, 0, 0, 1, 0, "R8 add ovf");
    issue(rf(6'h21, 1, 2, 10, 0), 32'h7FFF_FFFF, 32'h1, 1, 10, 32'h8000_0000, 0, 0, "R8 addu wrap");
    issue(rf(6'h22, 1, 2, 10, 0), 32'h8000_0000, 32'h1, 0, 0, 0, 1, 0, "R8 sub ovf");
    issue(rf(6'h23, 1, 2, 10, 0), 32'h8000_0000, 32'h1, 1, 10, 32'h7FFF_FFFF, 0, 0, "R8 subu wrap");
    issue(imf(6'h08, 1, 10, 16'h0001), 32'h7FFF_FFFF, 0, 0, 0, 0, 1, 0, "R8 addi ovf");
    issue(imf(6'h09, 1, 10, 16'h0001), 32'hFFFF_FFFF, 0, 1, 10, 32'h0, 0, 0, "R8 addiu wrap");
    idle();

    // R9 / R11: multiply then read back, move issued the very next cycle
    issue(rf(6'h18, 1, 2, 0, 0), 32'hFFFF_FFFD, 32'd5, 0, 0, 0, 0, 0, "R9 mult");
    issue(rf(6'h10, 0, 0, 11, 0), 0, 0, 1, 11, 32'hFFFF_FFFF, 0, 0, "R11 mfhi after mult");
    issue(rf(6'h12, 0, 0, 12, 0), 0, 0, 1, 12, 32'hFFFF_FFF1, 0, 0, "R11 mflo after mult");
    issue(rf(6'h19, 1, 2, 0, 0), 32'hFFFF_FFFD, 32'd5, 0, 0, 0, 0, 0, "R9 multu");
    issue(rf(6'h10, 0, 0, 11, 0), 0, 0, 1, 11, 32'h4, 0, 0, "R9 multu hi");
    issue(rf(6'h12, 0, 0, 12, 0), 0, 0, 1, 12, 32'hFFFF_FFF1, 0, 0, "R9 multu lo");

    // R10: divides
    issue(rf(6'h1A, 1, 2, 0, 0), 32'hFFFF_FFF9, 32'd2, 0, 0, 0, 0, 0, "R10 div");
    issue(rf(6'h12, 0, 0, 12, 0), 0, 0, 1, 12, 32'hFFFF_FFFD, 0, 0, "R10 div quotient");
    issue(rf(6'h10, 0, 0, 11, 0), 0, 0, 1, 11, 32'hFFFF_FFFF, 0, 0, "R10 div remainder");
    issue(rf(6'h1B, 1, 2, 0, 0), 32'hFFFF_FFF9, 32'd2, 0, 0, 0, 0, 0, "R10 divu");
    issue(rf(6'h12, 0, 0, 12, 0), 0, 0, 1, 12, 32'h7FFF_FFFC, 0, 0, "R10 divu quotient");
    issue(rf(6'h10, 0, 0, 11, 0), 0, 0, 1, 11, 32'h1, 0, 0, "R10 divu remainder");
    issue(rf(6'h1A, 1, 2, 0, 0), 32'd50, 32'd0, 0, 0, 0, 0, 0, "R10 div by zero");
    issue(rf(6'h12, 0, 0, 12, 0), 0, 0, 1, 12, 32'h7FFF_FFFC, 0, 0, "R10 lo held on zero divisor");
    issue(rf(6'h10, 0, 0, 11, 0), 0, 0, 1, 11, 32'h1, 0, 0, "R10 hi held on zero divisor");

    // R12: unknown encodings
    issue(rf(6'h3F, 1, 2, 13, 0), 32'd4, 32'd4, 0, 0, 0, 0, 1, "R12 bad function");
    issue(imf(6'h3F, 1, 13, 16'h1234), 32'd4, 0, 0, 0, 0, 0, 1, "R12 bad opcode");
    issue(rf(6'h12, 0, 0, 12, 0), 0, 0, 1, 12, 32'h7FFF_FFFC, 0, 0, "R12 lo unchanged");
    issue(rf(6'h10, 0, 0, 11, 0), 0, 0, 1, 11, 32'h1, 0, 0, "R12 hi unchanged");
    idle();

    repeat (4) @(negedge clk);
    chk("R2 all results seen", 64'(sb.size()), 64'd0);
    chk("R2 idle output", {63'd0, out_valid}, 64'd0);
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin repeat (5000) @(posedge clk); end
    join_any
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R2 actual=timeout expected=completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule